// File: doc/BRIEF.md
# Instruction Cycle and Flush Sequencer

This block is the front end of a small 8-bit controller core whose program words are 16 bits wide. It divides the oscillator clock into instruction cycles of four phases and drives one strobe per phase. Once per cycle it fetches the word at the program counter. At the edge that closes the cycle it moves that word into the execute position.

Every cycle has one of four kinds. A startup cycle is the first cycle after reset and executes nothing. An execute cycle runs the first word of an instruction. An operand cycle presents the second word of a two-word instruction. A flush cycle is a forced NOP that discards the word in the execute position.

The execute stage and a stub decoder supply three indications, all sampled at the edge that closes an execute or operand cycle:
- a two-word class flag for the word being executed;
- a taken flag with a target address;
- a skip flag.

From these the sequencer redirects the program counter and inserts flush cycles. It also turns any stray second word (one whose top four bits are all ones) into a flush cycle. Skipping over a two-word instruction therefore costs two flush cycles. The destination-select bit of byte-oriented operations is passed through to the execute stage.

Top module: `insn_cycle_seq`

## Requirements
- R1: `phaseStb` is one-hot at every clock. It is 4'b0001 during reset and advances one bit position per clock, from bit 0 up to bit 3 and back to bit 0. An instruction cycle is therefore four clocks long.
- R2: During reset and throughout the first cycle after reset, `pmAddr` is 0 and `execValid`, `forcedNop` and `opndValid` are all low. The word fetched from address 0 is executed in the second cycle.
- R3: The word on `pmWord` is captured at the clock edge that ends a cycle (bit 3 of `phaseStb` high). It appears on `execWord` for the whole next cycle. Unless the PC is redirected, `pmAddr` increases by one at that edge and stays constant within a cycle.
- R4: A single-word instruction that is neither taken nor skipping occupies one cycle. The next cycle is an execute cycle (`execValid` high) of the following word, unless R9 applies.
- R5: `exTaken` high at the end of an execute cycle with `isTwoWord` low loads `exTarget` into `pmAddr`. It also makes the next cycle a flush cycle (`forcedNop` high), so the instruction costs two cycles. When both are high, `exTaken` wins over `exSkip`.
- R6: `exSkip` high (with `exTaken` and `isTwoWord` low) at the end of an execute cycle makes the next cycle a flush cycle while `pmAddr` keeps counting up by one.
- R7: `isTwoWord` high at the end of an execute cycle makes the next cycle an operand cycle (`opndValid` high). In that cycle `opndWord` holds the word that followed the first word. Without a taken branch the instruction costs two cycles.
- R8: `exTaken` high at the end of an operand cycle loads `exTarget` into `pmAddr` and makes the next cycle a flush cycle. A taken two-word branch therefore costs three cycles.
- R9: A word whose bits 15:12 are 4'b1111 that would otherwise start an execute cycle gives a flush cycle instead. Skipping the first word of a two-word instruction therefore gives two flush cycles in a row.
- R10: The flags `exTaken`, `exSkip` and `isTwoWord` have no effect at the end of a flush or startup cycle. `exSkip` and `isTwoWord` have no effect at the end of an operand cycle.
- R11: `execDst` equals bit 9 of `execWord`. 0 selects the working register and 1 selects the addressed file register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pmWord | input | 16 | Program word read at `pmAddr` |
| isTwoWord | input | 1 | Stub decoder: the executing word starts a two-word instruction |
| exTaken | input | 1 | Execute stage: program counter is redirected |
| exSkip | input | 1 | Execute stage: conditional test true, skip next word |
| exTarget | input | 16 | Redirect target address |
| phaseStb | output | 4 | One-hot phase strobes |
| pmAddr | output | 16 | Program memory address (program counter) |
| execValid | output | 1 | Current cycle executes a first word |
| forcedNop | output | 1 | Current cycle is a flush cycle |
| opndValid | output | 1 | Current cycle carries a second word |
| execWord | output | 16 | Word in the execute position |
| execDst | output | 1 | Destination-select bit forwarded to execute |
| opndWord | output | 16 | Second word of the current two-word instruction |

## Verification
All cycle-level results (`pmAddr`, the three kind flags, `execWord`, `opndWord`, `execDst`) change at the edge that ends phase 3. The execute-stage indications that cause them are sampled on that same edge. The bench drives those indications at the falling edge opening phase 0, holds them for the whole cycle, and compares the cycle outputs at the next phase-0 falling edge, one cycle later. It checks the strobes at each of the three falling edges in between. Its reference model steps once per instruction cycle, so the costs of each instruction kind (1, 2 or 3 cycles, and 3 for a skip over a two-word instruction) show up as the cycle kind sequence it predicts.

// File: rtl/insn_cycle_seq_pkg.sv
package insn_cycle_seq_pkg;

  // kind of the instruction cycle currently in the execute position
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_EXEC   = 2'd1,
    CYC_SECOND = 2'd2,
    CYC_FLUSH  = 2'd3
  } cycKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cycEnd;    // this clock closes the instruction cycle
    logic redirect;  // load the target instead of incrementing
    logic keepOpnd;  // fetched word is a second word: keep it
  } seqStb_t;

endpackage

// File: rtl/insn_cycle_seq_ctrl.sv
module insn_cycle_seq_ctrl
  import insn_cycle_seq_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int TAIL_BITS  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TAIL_BITS-1:0]  fetchTop,
  input  logic                  isTwoWord,
  input  logic                  exTaken,
  input  logic                  exSkip,
  output logic [NUM_PHASES-1:0] phaseStb,
  output cycKind_e              cycKind,
  output seqStb_t               stb
);

  localparam int PH_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);

  logic [PH_W-1:0] phaseCnt;
  logic            lastPhase;
  logic            fetchTail;
  cycKind_e        nextKind;
  logic            redirectC;
  logic            keepOpndC;

  assign lastPhase = (phaseCnt == LAST_PH);
  assign fetchTail = &fetchTop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phaseCnt <= '0;
    else if (lastPhase) phaseCnt <= '0;
    else                phaseCnt <= phaseCnt + PH_W'(1);
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    assign phaseStb[g] = (phaseCnt == PH_W'(g));
  end

  // decide the kind of the following cycle
  always_comb begin
    redirectC = 1'b0;
    keepOpndC = 1'b0;
    nextKind  = fetchTail ? CYC_FLUSH : CYC_EXEC;
    unique case (cycKind)
      CYC_EXEC: begin
        if (isTwoWord) begin
          nextKind  = CYC_SECOND;
          keepOpndC = 1'b1;
        end else if (exTaken) begin
          nextKind  = CYC_FLUSH;
          redirectC = 1'b1;
        end else if (exSkip) begin
          nextKind  = CYC_FLUSH;
        end
      end
      CYC_SECOND: begin
        if (exTaken) begin
          nextKind  = CYC_FLUSH;
          redirectC = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cycKind <= CYC_IDLE;
    else if (lastPhase) cycKind <= nextKind;
  end

  assign stb.cycEnd   = lastPhase;
  assign stb.redirect = lastPhase & redirectC;
  assign stb.keepOpnd = lastPhase & keepOpndC;

endmodule

// File: rtl/insn_cycle_seq_dpath.sv
module insn_cycle_seq_dpath
  import insn_cycle_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [WORD_W-1:0] pmWord,
  input  logic [ADDR_W-1:0] exTarget,
  output logic [ADDR_W-1:0] pmAddr,
  output logic [WORD_W-1:0] execWord,
  output logic [WORD_W-1:0] opndWord
);

  logic [ADDR_W-1:0] pcReg;
  logic [WORD_W-1:0] instReg;
  logic [WORD_W-1:0] opndReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= '0;
    end else if (stb.cycEnd) begin
      pcReg <= stb.redirect ? exTarget : (pcReg + ADDR_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           instReg <= '0;
    else if (stb.cycEnd) instReg <= pmWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             opndReg <= '0;
    else if (stb.keepOpnd) opndReg <= pmWord;
  end

  assign pmAddr   = pcReg;
  assign execWord = instReg;
  assign opndWord = opndReg;

endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq
  import insn_cycle_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 16,
  parameter int NUM_PHASES = 4,
  parameter int TAIL_BITS  = 4,
  parameter int DST_BIT    = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WORD_W-1:0]     pmWord,
  input  logic                  isTwoWord,
  input  logic                  exTaken,
  input  logic                  exSkip,
  input  logic [ADDR_W-1:0]     exTarget,
  output logic [NUM_PHASES-1:0] phaseStb,
  output logic [ADDR_W-1:0]     pmAddr,
  output logic                  execValid,
  output logic                  forcedNop,
  output logic                  opndValid,
  output logic [WORD_W-1:0]     execWord,
  output logic                  execDst,
  output logic [WORD_W-1:0]     opndWord
);

  seqStb_t  stb;
  cycKind_e cycKind;

  insn_cycle_seq_ctrl #(
    .NUM_PHASES(NUM_PHASES),
    .TAIL_BITS (TAIL_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fetchTop (pmWord[WORD_W-1 -: TAIL_BITS]),
    .isTwoWord(isTwoWord),
    .exTaken  (exTaken),
    .exSkip   (exSkip),
    .phaseStb (phaseStb),
    .cycKind  (cycKind),
    .stb      (stb)
  );

  insn_cycle_seq_dpath #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .pmWord  (pmWord),
    .exTarget(exTarget),
    .pmAddr  (pmAddr),
    .execWord(execWord),
    .opndWord(opndWord)
  );

  assign execValid = (cycKind == CYC_EXEC);
  assign forcedNop = (cycKind == CYC_FLUSH);
  assign opndValid = (cycKind == CYC_SECOND);
  assign execDst   = execWord[DST_BIT];

endmodule

// File: rtl/insn_cycle_seq_chk.sv
module insn_cycle_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 16,
  parameter int NUM_PHASES = 4,
  parameter int TAIL_BITS  = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_PHASES-1:0] phaseStb,
  input logic [ADDR_W-1:0]     pmAddr,
  input logic [WORD_W-1:0]     pmWord,
  input logic                  isTwoWord,
  input logic                  exTaken,
  input logic                  exSkip,
  input logic [ADDR_W-1:0]     exTarget,
  input logic                  execValid,
  input logic                  forcedNop,
  input logic                  opndValid,
  input logic [WORD_W-1:0]     opndWord
);

  logic endCyc;
  logic fetchTail;
  assign endCyc    = phaseStb[NUM_PHASES-1];
  assign fetchTail = &pmWord[WORD_W-1 -: TAIL_BITS];

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(phaseStb) == 1);

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    endCyc |=> phaseStb[0]);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !endCyc |=> $stable(pmAddr));

  // R4
  kind_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({execValid, forcedNop, opndValid}) <= 1);

  // R5
  taken_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && execValid && !isTwoWord && exTaken)
      |=> (forcedNop && pmAddr == $past(exTarget)));

  // R6
  skip_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && execValid && !isTwoWord && !exTaken && exSkip)
      |=> (forcedNop && pmAddr == $past(pmAddr) + ADDR_W'(1)));

  // R7
  second_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && execValid && isTwoWord)
      |=> (opndValid && opndWord == $past(pmWord)));

  // R8
  second_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && opndValid && exTaken)
      |=> (forcedNop && pmAddr == $past(exTarget)));

  // R9
  tail_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && (forcedNop || opndValid) && !exTaken && fetchTail) |=> forcedNop);

  // R10
  flush_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && forcedNop && !fetchTail)
      |=> (execValid && pmAddr == $past(pmAddr) + ADDR_W'(1)));

  // R10
  second_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endCyc && opndValid && !exTaken && !fetchTail) |=> execValid);

endmodule

bind insn_cycle_seq insn_cycle_seq_chk #(
  .ADDR_W    (ADDR_W),
  .WORD_W    (WORD_W),
  .NUM_PHASES(NUM_PHASES),
  .TAIL_BITS (TAIL_BITS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .phaseStb (phaseStb),
  .pmAddr   (pmAddr),
  .pmWord   (pmWord),
  .isTwoWord(isTwoWord),
  .exTaken  (exTaken),
  .exSkip   (exSkip),
  .exTarget (exTarget),
  .execValid(execValid),
  .forcedNop(forcedNop),
  .opndValid(opndValid),
  .opndWord (opndWord)
);

// File: tb/sim_insn_cycle_seq.sv
`timescale 1ns/1ps
module sim_insn_cycle_seq;

  localparam int NCYC = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pmWord;
  logic        isTwoWord = 1'b0;
  logic        exTaken = 1'b0;
  logic        exSkip = 1'b0;
  logic [15:0] exTarget = '0;
  logic [3:0]  phaseStb;
  logic [15:0] pmAddr;
  logic        execValid, forcedNop, opndValid;
  logic [15:0] execWord, opndWord;
  logic        execDst;

  logic [15:0] mem [256];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign pmWord = mem[pmAddr[7:0]];

  insn_cycle_seq u0 (
    .clk(clk), .rstN(rstN), .pmWord(pmWord), .isTwoWord(isTwoWord),
    .exTaken(exTaken), .exSkip(exSkip), .exTarget(exTarget),
    .phaseStb(phaseStb), .pmAddr(pmAddr), .execValid(execValid),
    .forcedNop(forcedNop), .opndValid(opndValid), .execWord(execWord),
    .execDst(execDst), .opndWord(opndWord)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // bench program encoding: top nibble 1 = branch to low byte, 2 = skip,
  // C = first of two words, F = second word (bit 8 = taken, low byte = target)
  function automatic bit isTail(input logic [15:0] w);
    return w[15:12] == 4'hF;
  endfunction

  // kinds: 0 idle, 1 exec, 2 second, 3 flush
  int          refKind;
  logic [15:0] refPc, refInst, refOpnd;
  string       kindTag;
  string       addrTag;

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int a;
    logic [31:0] r;
    void'($urandom(32'd20251));
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // directed corner cases
    mem[0]  = 16'h0200;  // plain, d=1
    mem[1]  = 16'h1005;  // branch to 5
    mem[5]  = 16'h2000;  // skip
    mem[6]  = 16'hC000;  // skipped first word
    mem[7]  = 16'hF0AA;  // its second word
    mem[8]  = 16'hC123;  // two-word, not taken
    mem[9]  = 16'hF011;
    mem[10] = 16'hC000;  // two-word, taken to 14
    mem[11] = 16'hF10E;
    mem[14] = 16'hF555;  // stray second word
    mem[15] = 16'h2000;  // skip over a branch
    mem[16] = 16'h1000;
    mem[17] = 16'h0000;  // plain, d=0
    mem[18] = 16'h1020;  // branch to 32
    // random region
    a = 20;
    while (a < 256) begin
      r = $urandom;
      case (r[2:0])
        3'd3: mem[a] = {8'h10, 8'd20 + 8'(r[15:8] % 236)};
        3'd4: mem[a] = {4'h2, r[23:12]};
        3'd5: begin
          if (a < 255) begin
            mem[a] = {4'hC, r[27:16]};
            a++;
            mem[a] = {4'hF, 3'b000, r[8], 8'd20 + 8'(r[23:16] % 236)};
          end
        end
        3'd6: mem[a] = {4'hF, 3'b000, r[9], r[31:24]};
        default: mem[a] = {4'h0, r[27:16]};
      endcase
      a++;
    end

    // reset state
    repeat (3) @(negedge clk);
    chk(phaseStb == 4'b0001, "R1", "phase in reset", 32'(phaseStb), 32'h1);
    chk(pmAddr == 16'h0, "R2", "pmAddr in reset", 32'(pmAddr), 32'h0);
    chk({execValid, forcedNop, opndValid} == 3'b000, "R2", "flags in reset",
        32'({execValid, forcedNop, opndValid}), 32'h0);
    rstN = 1'b1;

    refKind = 0; refPc = '0; refInst = '0; refOpnd = '0;
    kindTag = "R2"; addrTag = "R2";

    for (int n = 0; n < NCYC; n++) begin
      logic [31:0] nz;
      logic [15:0] fetched;
      // cycle outputs at phase 0
      chk(phaseStb == 4'b0001, "R1", "phase 0", 32'(phaseStb), 32'h1);
      chk(pmAddr == refPc, addrTag, "pmAddr", 32'(pmAddr), 32'(refPc));
      chk(execValid == (refKind == 1), kindTag, "execValid", 32'(execValid), 32'(refKind == 1));
      chk(forcedNop == (refKind == 3), kindTag, "forcedNop", 32'(forcedNop), 32'(refKind == 3));
      chk(opndValid == (refKind == 2), kindTag, "opndValid", 32'(opndValid), 32'(refKind == 2));
      if (refKind != 0) begin
        chk(execWord == refInst, "R3", "execWord", 32'(execWord), 32'(refInst));
        chk(execDst == refInst[9], "R11", "execDst", 32'(execDst), 32'(refInst[9]));
      end
      if (refKind == 2)
        chk(opndWord == refOpnd, "R7", "opndWord", 32'(opndWord), 32'(refOpnd));

      // stub execute stage; noise on indications that must be ignored (R10)
      nz = $urandom;
      case (refKind)
        1: begin
          isTwoWord = (refInst[15:12] == 4'hC);
          exTaken   = (refInst[15:12] == 4'h1);
          exSkip    = (refInst[15:12] == 4'h2) || ((refInst[15:12] == 4'h1) && nz[0]);
          exTarget  = {8'h00, refInst[7:0]};
        end
        2: begin
          isTwoWord = nz[1];
          exTaken   = refOpnd[8];
          exSkip    = nz[2];
          exTarget  = {8'h00, refOpnd[7:0]};
        end
        default: begin
          isTwoWord = nz[3];
          exTaken   = nz[4];
          exSkip    = nz[5];
          exTarget  = nz[31:16];
        end
      endcase

      for (int p = 1; p < 4; p++) begin
        @(negedge clk);
        chk(phaseStb == 4'(1 << p), "R1", "phase rotate", 32'(phaseStb), 32'(1 << p));
      end

      // reference model step, from the requirements
      fetched = mem[refPc[7:0]];
      addrTag = "R3";
      kindTag = isTail(fetched) ? "R9" : "R4";
      if (refKind == 1 && isTwoWord) begin
        refKind = 2; refOpnd = fetched; refPc = refPc + 16'd1; kindTag = "R7";
      end else if (refKind == 1 && exTaken) begin
        refKind = 3; refPc = exTarget; kindTag = "R5"; addrTag = "R5";
      end else if (refKind == 1 && exSkip) begin
        refKind = 3; refPc = refPc + 16'd1; kindTag = "R6";
      end else if (refKind == 2 && exTaken) begin
        refKind = 3; refPc = exTarget; kindTag = "R8"; addrTag = "R8";
      end else begin
        if (refKind == 3 || refKind == 2) kindTag = isTail(fetched) ? "R9" : "R10";
        refKind = isTail(fetched) ? 3 : 1;
        refPc = refPc + 16'd1;
      end
      refInst = fetched;
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule